// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder/Subtractor

This block adds or subtracts two unsigned binary words in a single combinational pass. It has no registers: the sum and carry-out settle from the operands, the mode pin and the carry input within the same cycle. A host places it inside a datapath stage and samples the result with its own flops.

Carries are not rippled. Each bit forms a generate term (both operand bits set) and a propagate term (either bit set). A single four-input lookahead unit is used throughout the tree. At the leaf level, one unit turns four bit pairs plus a carry-in into three internal carries and one group generate/propagate pair. The same unit then combines four groups into a 16-bit section, and, at 64 bits, four sections into the whole word. The tree is walked back downward so that every bit receives its carry in parallel.

Subtraction inverts the second operand and forces the initial carry to one, so the word computed is `a + ~b + 1`.

Top module: `cla_adder`

## Requirements
- R1: With `sub_en` = 0, `result` equals `(op_a + op_b + carry_in) mod 2^WIDTH`.
- R2: With `sub_en` = 0, `carry_out` equals bit WIDTH of the full-width sum `op_a + op_b + carry_in`.
- R3: With `sub_en` = 1, `result` equals `(op_a - op_b) mod 2^WIDTH`, formed as `op_a + ~op_b + 1`.
- R4: With `sub_en` = 1, `carry_out` is 1 exactly when `op_a >= op_b` as unsigned numbers, so 0 flags a borrow.
- R5: With `sub_en` = 1, `carry_in` has no effect on `result` or `carry_out`.
- R6: A carry entering bit 0 travels through every group and section. All-ones plus one (carry-in 0) gives `result` 0 and `carry_out` 1. In 4-bit terms the pattern is 1111 + 0001.
- R7: `WIDTH` may be 16 (two lookahead levels) or 64 (three lookahead levels), and R1–R6 hold at both widths. For example, 5 - 2 gives 3 with `carry_out` 1.
- R8: The block is purely combinational. With all inputs at 0, `result` is 0 and `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| carry_in | input | 1 | Carry into bit 0 during addition; ignored while subtracting |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit (1 = no borrow when subtracting) |

## Verification
Two things can act on the initial carry in the same cycle: the forced carry from subtract mode and the external carry input. The bench drives both together, applying subtraction once with `carry_in` low and once with it high on the same operands, and requires identical outputs that match the unsigned difference. It also pairs subtract mode with operands whose inverted subtrahend makes every group propagate, such as equal operands. In that case the forced carry must cross the whole tree in the same evaluation, and the expected result is zero with `carry_out` set.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Fan-in of the lookahead unit at every level of the tree.
  localparam int unsigned BLOCK = 4;

  // Number of lookahead levels for a width that is a power of four.
  function automatic int unsigned levels_for(input int unsigned width);
    int unsigned n;
    int unsigned lv;
    n  = width;
    lv = 0;
    while (n > 1) begin
      n  = n / BLOCK;
      lv = lv + 1;
    end
    return lv;
  endfunction
endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] half_sum
);
  // Per-bit generate (AND), propagate (OR) and carry-less sum (XOR).
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]      = x[i] & y[i];
    assign prop[i]     = x[i] | y[i];
    assign half_sum[i] = x[i] ^ y[i];
  end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] g_in,
  input  logic [3:0] p_in,
  input  logic       c_in,
  output logic [3:1] c_mid,
  output logic       g_out,
  output logic       p_out
);
  // Two-level sum-of-products carries into slots 1..3.
  assign c_mid[1] = g_in[0]
                  | (p_in[0] & c_in);
  assign c_mid[2] = g_in[1]
                  | (p_in[1] & g_in[0])
                  | (p_in[1] & p_in[0] & c_in);
  assign c_mid[3] = g_in[2]
                  | (p_in[2] & g_in[1])
                  | (p_in[2] & p_in[1] & g_in[0])
                  | (p_in[2] & p_in[1] & p_in[0] & c_in);

  // Block-level terms that feed the next level up.
  assign g_out = g_in[3]
               | (p_in[3] & g_in[2])
               | (p_in[3] & p_in[2] & g_in[1])
               | (p_in[3] & p_in[2] & p_in[1] & g_in[0]);
  assign p_out = &p_in;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  import cla_pkg::*;

  localparam int unsigned LEVELS = levels_for(WIDTH);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] half_sum;
  logic             c_first;

  // The forced carry of subtraction overrides the external carry.
  assign b_eff   = sub_en ? ~op_b : op_b;
  assign c_first = sub_en ? 1'b1 : carry_in;

  // Per-level signal sets. Level l holds WIDTH/4^l generate/propagate pairs
  // and the carries entering each of them.
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
    localparam int unsigned N = WIDTH >> (2 * l);
    logic [N-1:0] g;
    logic [N-1:0] p;
    logic [N-1:0] c;
  end

  cla_bit_gp #(.WIDTH(WIDTH)) u_bit_gp (
    .x        (op_a),
    .y        (b_eff),
    .gen      (g_lv[0].g),
    .prop     (g_lv[0].p),
    .half_sum (half_sum)
  );

  // The same lookahead unit at every level: up-sweep of g/p, down-sweep of carries.
  for (genvar l = 0; l < LEVELS; l++) begin : g_tree
    localparam int unsigned NODES = WIDTH >> (2 * (l + 1));
    for (genvar j = 0; j < NODES; j++) begin : g_node
      logic [3:1] mid;
      cla_lookahead4 u_la (
        .g_in  (g_lv[l].g[4*j +: 4]),
        .p_in  (g_lv[l].p[4*j +: 4]),
        .c_in  (g_lv[l+1].c[j]),
        .c_mid (mid),
        .g_out (g_lv[l+1].g[j]),
        .p_out (g_lv[l+1].p[j])
      );
      assign g_lv[l].c[4*j]         = g_lv[l+1].c[j];
      assign g_lv[l].c[4*j+3:4*j+1] = mid;
    end
  end

  assign g_lv[LEVELS].c[0] = c_first;

  assign result    = half_sum ^ g_lv[0].c;
  assign carry_out = g_lv[LEVELS].g[0] | (g_lv[LEVELS].p[0] & c_first);
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 64
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_en,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [WIDTH:0] ref_add;
  logic [WIDTH:0] ref_diff;

  always_comb begin
    ref_add  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    ref_diff = {1'b0, op_a} - {1'b0, op_b};
    if (!sub_en) begin
      // R1 and R2: behavioural sum against the lookahead tree
      a_r1_add_sum:   assert (result === ref_add[WIDTH-1:0]);
      a_r2_add_carry: assert (carry_out === ref_add[WIDTH]);
    end else begin
      // R3, R4 and R5: carry_in is absent from the reference
      a_r3_sub_diff:   assert (result === ref_diff[WIDTH-1:0]);
      a_r4_sub_borrow: assert (carry_out === (op_a >= op_b));
    end
    // R6: the full-length carry chain
    if (!sub_en && !carry_in && (&op_a) && op_b == {{(WIDTH-1){1'b0}}, 1'b1}) begin
      a_r6_long_chain: assert (result == '0 && carry_out);
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_cla_adder_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .sub_en    (sub_en),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/test_cla_adder.sv
`timescale 1ns/1ps
module test_cla_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [63:0] a64, b64, r64;
  logic [15:0] a16, b16, r16;
  logic        sub, cin, co64, co16;

  int n_chk = 0;
  int n_err = 0;

  cla_adder #(.WIDTH(64)) i_cla_adder (
    .op_a(a64), .op_b(b64), .sub_en(sub), .carry_in(cin),
    .result(r64), .carry_out(co64)
  );

  cla_adder #(.WIDTH(16)) i_cla_adder_w16 (
    .op_a(a16), .op_b(b16), .sub_en(sub), .carry_in(cin),
    .result(r16), .carry_out(co16)
  );

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one vector to both widths and check the results against the
  // requirement arithmetic (carry_in is ignored in subtract mode).
  task automatic run_vec(input string tr, input string tc,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic s, input logic c);
    logic [64:0] e64;
    logic [16:0] e16;
    @(negedge clk);
    a64 = a; b64 = b; a16 = a[15:0]; b16 = b[15:0]; sub = s; cin = c;
    #1;
    if (s) begin
      e64 = {1'b0, a} - {1'b0, b};
      e16 = {1'b0, a[15:0]} - {1'b0, b[15:0]};
      e64[64] = (a >= b);
      e16[16] = (a[15:0] >= b[15:0]);
    end else begin
      e64 = {1'b0, a} + {1'b0, b} + {64'd0, c};
      e16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, c};
    end
    chk({tr, " w64 result"},  {1'b0, r64},           {1'b0, e64[63:0]});
    chk({tc, " w64 carry"},   {64'd0, co64},         {64'd0, e64[64]});
    chk({tr, " R7 w16 result"}, {49'd0, r16},        {49'd0, e16[15:0]});
    chk({tc, " R7 w16 carry"},  {64'd0, co16},       {64'd0, e16[16]});
  endtask

  task automatic t_idle_zero;  // R8
    run_vec("R8", "R8", 64'd0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_add_patterns;  // R1 R2
    run_vec("R1", "R2", 64'd5, 64'd2, 1'b0, 1'b0);
    run_vec("R1", "R2", 64'h00F0_00F0_00F0_00F0, 64'h0010_0010_0010_0010, 1'b0, 1'b1);
    run_vec("R1", "R2", 64'h8000_0000_0000_8000, 64'h8000_0000_0000_8000, 1'b0, 1'b0);
    run_vec("R1", "R2", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, 1'b1);
  endtask

  task automatic t_long_chain;  // R6
    run_vec("R6", "R6", {64{1'b1}}, 64'd1, 1'b0, 1'b0);
    run_vec("R6", "R6", {64{1'b1}}, 64'd0, 1'b0, 1'b1);
    run_vec("R6", "R6", {64{1'b1}}, {64{1'b1}}, 1'b0, 1'b1);
    run_vec("R6", "R6", 64'h0000_FFFF_0000_000F, 64'd1, 1'b0, 1'b0);
  endtask

  task automatic t_sub_basic;  // R3 R4 R7
    run_vec("R3", "R4", 64'd5, 64'd2, 1'b1, 1'b0);
    run_vec("R3", "R4", 64'd2, 64'd5, 1'b1, 1'b0);
    run_vec("R3", "R4", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0);
    run_vec("R3", "R4", 64'd0, 64'd1, 1'b1, 1'b0);
  endtask

  task automatic t_sub_cin_ignored;  // R5
    run_vec("R5", "R5", 64'd100, 64'd40, 1'b1, 1'b1);
    run_vec("R5", "R5", 64'd40, 64'd100, 1'b1, 1'b1);
    run_vec("R5", "R5", 64'hFFFF_0000_FFFF_0000, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b1);
  endtask

  task automatic t_random;  // R1 R2 R3 R4
    for (int i = 0; i < 200; i++) begin
      logic [63:0] a, b;
      logic s, c;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      s = 1'($urandom);
      c = 1'($urandom);
      if (s) run_vec("R3", "R4", a, b, s, c);
      else   run_vec("R1", "R2", a, b, s, c);
    end
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    a64 = '0; b64 = '0; a16 = '0; b16 = '0; sub = 1'b0; cin = 1'b0;
    t_idle_zero();
    t_add_patterns();
    t_long_chain();
    t_sub_basic();
    t_sub_cin_ignored();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule